// File: doc/BRIEF.md
# Prescaled Pulse-Width Modulator

This block produces one or two independent pulse-width modulated outputs from a single clock. Each channel has a control word (prescale divider and stop style), a duty word (high-time count and a force-high flag) and a period word. A plain synchronous write/read port with a byte address reaches them. The prescaler divides the clock. A period counter then steps once per divided tick. The output is high from the start of each period until the duty count runs out.

A per-channel enable input starts and stops each channel. A channel always starts a period from its beginning. When the enable drops, the channel either stops on the next clock or finishes the period it is in, as its control word selects. New values written to a running channel are staged and take effect only at the next period boundary. A period therefore never mixes old and new settings.

Top module: `pulse_mod_unit`

## Requirements
- R1: After reset every register reads zero and both outputs are low. An idle channel whose enable is low keeps its output low.
- R2: The address is a byte offset. Bits [3:2] pick the word: 0 is control, 1 is duty, 2 is period, and 3 always reads zero with writes ignored. Bit 4 picks the channel. The control word holds the prescale value P in bits [5:0] and the abrupt-stop flag in bit 6. The duty word holds the count D in bits [9:0] and the force-high flag in bit 10. The period word holds V in bits [9:0]. A read returns the last written value with all other bits zero.
- R3: A channel started from idle drives its output high in the first cycle after the clock edge that samples its enable high. Each period lasts (P+1)*(V+1) cycles, and the output is high for the first (P+1)*D cycles of it.
- R4: A duty count of zero keeps the output low for the whole period.
- R5: With the force-high flag set, the output stays high for the whole period, whatever D holds.
- R6: A duty count larger than V+1 saturates, and the output stays high for the whole period.
- R7: With the abrupt-stop flag set, the output is low from the first cycle after the edge that samples the enable low, and the channel returns to idle.
- R8: With the abrupt-stop flag clear, the output continues through the end of the current period and is then held low. If the enable is sampled low exactly at a period boundary, the output is low from that boundary on.
- R9: Prescale, duty and period values written while a channel runs take effect only at the next period boundary.
- R10: The two channels run independently. Running one leaves the other's output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; also the clock that the prescaler divides |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe for the word at addr_i |
| addr_i | input | ADDR_W | Byte address of the word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| chan_en_i | input | NUM_CH | Per-channel run enable |
| pwm_o | output | NUM_CH | Per-channel output, active high |

## Verification
The hardest case to reach is a register write that lands mid-period. It must leave the running period untouched and show up only in the next one. The bench starts a channel and writes a new duty count one cycle later. It then holds the enable long enough for the boundary to pass, and the scoreboard expects the old pattern followed by the new one. A graceful stop is also timed to fall exactly on a period boundary, which separates it from a stop one cycle earlier or later.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int DATA_W = 32;
  localparam int PRE_W  = 6;
  localparam int DC_W   = 10;
  localparam int PV_W   = 10;

  localparam logic [1:0] SEL_CTL  = 2'd0;
  localparam logic [1:0] SEL_DUTY = 2'd1;
  localparam logic [1:0] SEL_PER  = 2'd2;

  typedef struct packed {
    logic             abrupt;
    logic [PRE_W-1:0] pre;
  } ctl_t;

  typedef struct packed {
    logic            full;
    logic [DC_W-1:0] dc;
  } duty_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output ctl_t              ctl_o  [NUM_CH],
  output duty_t             duty_o [NUM_CH],
  output logic [PV_W-1:0]   per_o  [NUM_CH]
);
  localparam int CH_SEL_W = ADDR_W - 4;

  logic [CH_SEL_W-1:0] ch_sel;
  logic [1:0]          word_sel;
  logic                unused_addr;
  logic                unused_wdata;

  assign ch_sel       = addr_i[ADDR_W-1:4];
  assign word_sel     = addr_i[3:2];
  assign unused_addr  = ^addr_i[1:0];
  assign unused_wdata = ^wdata_i[DATA_W-1:DC_W+1];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic wr_ch;
    assign wr_ch = wr_i && (ch_sel == CH_SEL_W'(i));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        ctl_o[i]  <= '0;
        duty_o[i] <= '0;
        per_o[i]  <= '0;
      end else if (wr_ch) begin
        unique case (word_sel)
          SEL_CTL:  ctl_o[i]  <= ctl_t'(wdata_i[PRE_W:0]);
          SEL_DUTY: duty_o[i] <= duty_t'(wdata_i[DC_W:0]);
          SEL_PER:  per_o[i]  <= wdata_i[PV_W-1:0];
          default:  ;
        endcase
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel == CH_SEL_W'(i)) begin
        unique case (word_sel)
          SEL_CTL:  rdata_o = DATA_W'(ctl_o[i]);
          SEL_DUTY: rdata_o = DATA_W'(duty_o[i]);
          SEL_PER:  rdata_o = DATA_W'(per_o[i]);
          default:  rdata_o = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan
  import pwm_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  ctl_t            ctl_i,
  input  duty_t           duty_i,
  input  logic [PV_W-1:0] per_i,
  output logic            pwm_o,
  output logic            run_o,
  output logic            wrap_o
);
  logic             run_q;
  logic [PRE_W-1:0] pre_cnt_q, pre_act_q;
  logic [PV_W-1:0]  per_cnt_q, pv_act_q;
  logic [DC_W-1:0]  dc_act_q;
  logic             full_act_q;
  logic             tick;

  assign tick   = (pre_cnt_q == pre_act_q);
  assign wrap_o = run_q && tick && (per_cnt_q == pv_act_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= 1'b0;
      pre_cnt_q  <= '0;
      per_cnt_q  <= '0;
      pre_act_q  <= '0;
      pv_act_q   <= '0;
      dc_act_q   <= '0;
      full_act_q <= 1'b0;
    end else if (!run_q) begin
      if (en_i) begin
        run_q      <= 1'b1;
        pre_cnt_q  <= '0;
        per_cnt_q  <= '0;
        pre_act_q  <= ctl_i.pre;
        pv_act_q   <= per_i;
        dc_act_q   <= duty_i.dc;
        full_act_q <= duty_i.full;
      end
    end else if (!en_i && ctl_i.abrupt) begin
      run_q     <= 1'b0;
      pre_cnt_q <= '0;
      per_cnt_q <= '0;
    end else if (wrap_o) begin
      // staged values become active only here
      run_q      <= en_i;
      pre_cnt_q  <= '0;
      per_cnt_q  <= '0;
      pre_act_q  <= ctl_i.pre;
      pv_act_q   <= per_i;
      dc_act_q   <= duty_i.dc;
      full_act_q <= duty_i.full;
    end else if (tick) begin
      pre_cnt_q <= '0;
      per_cnt_q <= per_cnt_q + 1'b1;
    end else begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end

  // per_cnt never exceeds pv, so dc > pv+1 saturates naturally
  assign pwm_o = run_q && (full_act_q || (per_cnt_q < dc_act_q));
  assign run_o = run_q;
endmodule

// File: rtl/pulse_mod_unit.sv
module pulse_mod_unit
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [NUM_CH-1:0] chan_en_i,
  output logic [NUM_CH-1:0] pwm_o
);
  ctl_t              ctl_w  [NUM_CH];
  duty_t             duty_w [NUM_CH];
  logic [PV_W-1:0]   per_w  [NUM_CH];
  logic [NUM_CH-1:0] run_w;
  logic [NUM_CH-1:0] wrap_w;

  pwm_regs #(
    .NUM_CH (NUM_CH),
    .ADDR_W (ADDR_W)
  ) i_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (wr_i),
    .addr_i  (addr_i),
    .wdata_i (wdata_i),
    .rdata_o (rdata_o),
    .ctl_o   (ctl_w),
    .duty_o  (duty_w),
    .per_o   (per_w)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
    pwm_chan i_chan (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (chan_en_i[i]),
      .ctl_i  (ctl_w[i]),
      .duty_i (duty_w[i]),
      .per_i  (per_w[i]),
      .pwm_o  (pwm_o[i]),
      .run_o  (run_w[i]),
      .wrap_o (wrap_w[i])
    );
  end
endmodule

// File: rtl/pulse_mod_unit_chk.sv
module pulse_mod_unit_chk
  import pwm_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [NUM_CH-1:0] chan_en_i,
  input logic [NUM_CH-1:0] pwm_o,
  input logic [NUM_CH-1:0] run,
  input logic [NUM_CH-1:0] wrap,
  input ctl_t              ctl [NUM_CH],
  input logic [1:0]        word_sel,
  input logic [DATA_W-1:0] rdata_o
);
  p_gap_zero_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (word_sel == 2'b11) |-> (rdata_o == '0));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
    p_idle_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run[i] && !chan_en_i[i]) |=> !pwm_o[i]);

    p_start_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run[i] && chan_en_i[i]) |=> run[i]);

    p_abrupt_stop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run[i] && !chan_en_i[i] && ctl[i].abrupt) |=> (!run[i] && !pwm_o[i]));

    p_graceful_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run[i] && !chan_en_i[i] && !ctl[i].abrupt && !wrap[i]) |=> run[i]);

    p_drain_end_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap[i] && !chan_en_i[i]) |=> !pwm_o[i]);
  end
endmodule

bind pulse_mod_unit pulse_mod_unit_chk #(
  .NUM_CH (NUM_CH)
) i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .chan_en_i (chan_en_i),
  .pwm_o     (pwm_o),
  .run       (run_w),
  .wrap      (wrap_w),
  .ctl       (ctl_w),
  .word_sel  (addr_i[3:2]),
  .rdata_o   (rdata_o)
);

// File: tb/test_pulse_mod_unit.sv
`timescale 1ns/1ps
module test_pulse_mod_unit;
  localparam int NUM_CH = 2;
  localparam int ADDR_W = 5;

  typedef struct {
    logic [NUM_CH-1:0] exp;
    string             tag;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NUM_CH-1:0] en = '0;
  logic [NUM_CH-1:0] pwm;

  int    n_chk = 0;
  int    n_err = 0;
  bit    done = 0;
  item_t sb_q[$];

  always #2.5 clk = ~clk;

  pulse_mod_unit #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) i_pulse_mod_unit (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .chan_en_i(en), .pwm_o(pwm)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // monitor: one scoreboard item per cycle, sampled 1ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() != 0) begin
        item_t it;
        it = sb_q.pop_front();
        check(it.tag, 32'(pwm), 32'(it.exp));
      end
    end
  end

  task automatic wr_word(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_check(input logic [ADDR_W-1:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    addr = a;
    #1;
    check(tag, rdata, exp);
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic scen(input int ch, input int pre, input int dc, input int pv,
                      input bit fd, input bit abrupt, input int non, input string tag);
    logic [ADDR_W-1:0] base;
    int L, endc;
    base = ADDR_W'(ch * 16);
    @(negedge clk);
    wr_word(base + 0, (32'(abrupt) << 6) | 32'(pre));
    wr_word(base + 4, (32'(fd) << 10) | 32'(dc));
    wr_word(base + 8, 32'(pv));
    L = (pre + 1) * (pv + 1);
    endc = abrupt ? non : ((non + L - 1) / L) * L;
    en[ch] = 1'b1;
    for (int c = 0; c < endc + 4; c++) begin
      item_t it;
      int pos, k;
      bit b;
      pos = c % L;
      k = pos / (pre + 1);
      b = (c < endc) && (fd || (k < dc));
      it.exp = NUM_CH'(b) << ch;
      it.tag = tag;
      sb_q.push_back(it);
    end
    repeat (non) @(negedge clk);
    en[ch] = 1'b0;
    drain();
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 outputs low", 32'(pwm), 0);
    for (int a = 0; a < 32; a += 4) rd_check(ADDR_W'(a), 0, "R1 reset read");

    // R2: field masks and map
    @(negedge clk);
    wr_word(5'h00, 32'hFFFF_FFFF);
    wr_word(5'h04, 32'hFFFF_FFFF);
    wr_word(5'h08, 32'hFFFF_FFFF);
    wr_word(5'h0C, 32'hFFFF_FFFF);
    wr_word(5'h18, 32'h0000_0005);
    rd_check(5'h00, 32'h7F,  "R2 ctl mask");
    rd_check(5'h04, 32'h7FF, "R2 duty mask");
    rd_check(5'h08, 32'h3FF, "R2 period mask");
    rd_check(5'h0C, 32'h0,   "R2 gap word");
    rd_check(5'h18, 32'h5,   "R2 ch1 period");
    rd_check(5'h10, 32'h0,   "R2 ch1 ctl untouched");
    check("R1 idle outputs low", 32'(pwm), 0);

    scen(0, 1, 2, 4, 0, 1, 25, "R3/R7 abrupt mid-period");
    scen(0, 0, 3, 5, 0, 0, 8,  "R8 graceful mid-period");
    scen(0, 0, 3, 5, 0, 0, 12, "R8 graceful at boundary");
    scen(0, 2, 0, 3, 0, 1, 12, "R4 zero duty");
    scen(0, 0, 1, 4, 1, 1, 10, "R5 force high");
    scen(0, 1, 9, 3, 0, 0, 8,  "R6 saturated duty");
    scen(1, 2, 1, 2, 0, 1, 14, "R10 ch1 alone");

    // R9: mid-period duty write is staged until the boundary
    @(negedge clk);
    wr_word(5'h00, 32'h40);
    wr_word(5'h04, 32'd1);
    wr_word(5'h08, 32'd3);
    en[0] = 1'b1;
    for (int c = 0; c < 11; c++) begin
      item_t it;
      bit b;
      if (c < 4)      b = (c < 1);
      else if (c < 8) b = ((c - 4) < 3);
      else            b = 1'b0;
      it.exp = NUM_CH'(b);
      it.tag = "R9 staged duty";
      sb_q.push_back(it);
    end
    @(negedge clk);
    wr_word(5'h04, 32'd3);
    repeat (6) @(negedge clk);
    en[0] = 1'b0;
    drain();
    rd_check(5'h04, 32'd3, "R9 duty readback");

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule